// File: doc/BRIEF.md
# Dual-Source Numerically Controlled Oscillator

This block is a numerically controlled oscillator built on a 32-bit phase accumulator. On every sample clock the accumulator adds the active tuning word and wraps modulo 2^32. The output frequency is tuning_word × fs / 2^32. At a 50 MSPS sample rate, the tuning word 0x00014F8B (85899) gives about 1 kHz. The block presents the full accumulator phase. It also presents a 12-bit truncated phase index that a downstream waveform lookup can use.

The tuning word comes from one of two sources, and a select input picks between them. The first source is a 32-bit word that a bus-mapped output register drives into the block; here it is only an input port. The second source is a serial debug shift register, which lets the oscillator be steered without any bus traffic. Serial bits enter it MSB first, one bit per clock while the shift enable is high. A separate load strobe copies the shifted pattern into a held debug word. The active tuning word is registered once per clock from the selected source. Changing the source or the word never disturbs the running phase.

Top module: `nco_dual_src`

## Requirements
- R1: While `rst` is high at a rising clock edge, the accumulator, the active tuning word, the debug shift register and the held debug word are all cleared to zero, so `phase_acc` and `phase_idx` read 0 afterwards.
- R2: Out of reset, every rising edge replaces `phase_acc` with (`phase_acc` + active tuning word) mod 2^32, so a sum past 2^32-1 wraps around with no saturation.
- R3: At an edge where `dbg_shift_en` is 1, the debug shift register moves up one place and takes `dbg_bit` into bit 0. After 32 such shifts, the first bit shifted in sits in bit 31 (MSB first).
- R4: The held debug word changes only at an edge where `dbg_load` is 1. It then takes the shift register value from before that edge, so a shift in the same cycle is not included. With `dbg_load` at 0, the word is kept even while bits are being shifted.
- R5: `src_sel` = 1 selects the held debug word as the tuning source. `src_sel` = 0 selects `bus_word`.
- R6: The source value seen at edge k becomes the active tuning word at edge k. It is first added to the phase at edge k+1. Neither a new word nor a source switch resets or otherwise disturbs the accumulator.
- R7: `phase_idx` always equals `phase_acc[31:20]`, the 12 most significant phase bits.
- R8: Out of reset with a constant tuning word of 0x00014F8B, the accumulator first wraps (reads lower than on the previous clock) on clock 50002 after reset release. This counts one clock to register the word, which gives about 1 kHz at 50 MSPS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | Tuning source: 0 bus word, 1 debug word |
| bus_word | input | 32 | Tuning word from the bus-mapped register |
| dbg_shift_en | input | 1 | Shift one serial bit into the debug register |
| dbg_bit | input | 1 | Serial debug data bit |
| dbg_load | input | 1 | Copy the debug shift register into the held debug word |
| phase_acc | output | 32 | Phase accumulator value |
| phase_idx | output | 12 | Truncated phase for a waveform lookup |

## Verification
Two pairs of functions can land on the same edge. In the first, a serial shift and a load strobe meet: the bench drives `dbg_shift_en` and `dbg_load` together, both in directed steps and in random ones. It then judges, through the phase increments, that the loaded word left out the bit that arrived in that cycle. In the second, a tuning word change meets an accumulation step: the bench switches `bus_word` or `src_sel` on one edge. It checks that the increment at that edge still uses the old word, that the increment at the next edge uses the new one, and that the phase carries on without being cleared.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int unsigned PHASE_W = 32;
    localparam int unsigned IDX_W   = 12;

    typedef enum logic {
        SRC_BUS = 1'b0,
        SRC_DBG = 1'b1
    } tune_src_e;
endpackage

// File: rtl/nco_dbg_shreg.sv
module nco_dbg_shreg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         shift_bit,
    input  logic         load,
    output logic [W-1:0] shreg_q,
    output logic [W-1:0] word_q
);
    // serial path: MSB first, new bit enters at bit 0
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
        end else if (shift_en) begin
            shreg_q <= {shreg_q[W-2:0], shift_bit};
        end
    end

    // held word: only the strobe updates it, using the pre-shift value
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= shreg_q;
        end
    end

    // R4: without a strobe the held word stays put
    p_dbg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q));
endmodule

// File: rtl/nco_tune_sel.sv
module nco_tune_sel
    import nco_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  tune_src_e    src,
    input  logic [W-1:0] bus_word,
    input  logic [W-1:0] dbg_word,
    output logic [W-1:0] tw_q
);
    logic [W-1:0] tw_next;

    always_comb begin
        unique case (src)
            SRC_BUS: tw_next = bus_word;
            SRC_DBG: tw_next = dbg_word;
            default: tw_next = bus_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tw_q <= '0;
        end else begin
            tw_q <= tw_next;
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     tw,
    output logic [W-1:0]     acc_q,
    output logic [IDX_W-1:0] idx
);
    localparam int unsigned IDX_LSB = W - IDX_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_q + tw;
        end
    end

    assign idx = acc_q[W-1:IDX_LSB];

    // R2: step size matches the tuning word seen one clock earlier
    p_acc_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (acc_q - $past(acc_q)) == $past(tw));
endmodule

// File: rtl/nco_dual_src.sv
module nco_dual_src
    import nco_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               src_sel,
    input  logic [PHASE_W-1:0] bus_word,
    input  logic               dbg_shift_en,
    input  logic               dbg_bit,
    input  logic               dbg_load,
    output logic [PHASE_W-1:0] phase_acc,
    output logic [IDX_W-1:0]   phase_idx
);
    logic [PHASE_W-1:0] shreg_w;
    logic [PHASE_W-1:0] dbg_word_w;
    logic [PHASE_W-1:0] tw_w;
    tune_src_e          src_w;

    assign src_w = tune_src_e'(src_sel);

    nco_dbg_shreg #(.W(PHASE_W)) u_dbg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (dbg_shift_en),
        .shift_bit(dbg_bit),
        .load     (dbg_load),
        .shreg_q  (shreg_w),
        .word_q   (dbg_word_w)
    );

    nco_tune_sel #(.W(PHASE_W)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .src     (src_w),
        .bus_word(bus_word),
        .dbg_word(dbg_word_w),
        .tw_q    (tw_w)
    );

    nco_phase_acc #(.W(PHASE_W), .IDX_W(IDX_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .tw   (tw_w),
        .acc_q(phase_acc),
        .idx  (phase_idx)
    );

    // R1: reset leaves phase and tuning word at zero
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (phase_acc == '0) && (tw_w == '0));

    // R5: on the bus path the active word follows the bus input
    p_bus_path_r5: assert property (@(posedge clk) disable iff (rst)
        !src_sel |=> tw_w == $past(bus_word));

    // R4/R5: a strobe on the debug path reaches the active word two clocks later
    p_dbg_path_r5: assert property (@(posedge clk) disable iff (rst)
        (dbg_load ##1 src_sel) |=> tw_w == $past(shreg_w, 2));

    // R7: index tracks the top phase bits
    p_idx_top_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase_idx == $past(phase_acc + tw_w, 1) >> (PHASE_W - IDX_W));
endmodule

// File: tb/nco_dual_src_tb_top.sv
module nco_dual_src_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_sel = 1'b0;
    logic [31:0] bus_word = '0;
    logic        dbg_shift_en = 1'b0;
    logic        dbg_bit = 1'b0;
    logic        dbg_load = 1'b0;
    logic [31:0] phase_acc;
    logic [11:0] phase_idx;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;

    // reference state from the requirements
    logic [31:0] m_acc = '0, m_tw = '0, m_sh = '0, m_dbg = '0;
    logic [31:0] prev_acc;

    always #5 clk = ~clk;

    nco_dual_src dut_i (
        .clk(clk), .rst(rst), .src_sel(src_sel), .bus_word(bus_word),
        .dbg_shift_en(dbg_shift_en), .dbg_bit(dbg_bit), .dbg_load(dbg_load),
        .phase_acc(phase_acc), .phase_idx(phase_idx)
    );

    function automatic logic [11:0] top_bits(input logic [31:0] a);
        return a[31:20];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive at negedge, update model at posedge, compare after
    task automatic step(input logic sel, input logic [31:0] bw, input logic se,
                        input logic sb, input logic ld);
        logic [31:0] n_acc, n_tw, n_sh, n_dbg;
        src_sel = sel; bus_word = bw; dbg_shift_en = se; dbg_bit = sb; dbg_load = ld;
        @(posedge clk);
        if (rst) begin
            n_acc = '0; n_tw = '0; n_sh = '0; n_dbg = '0;
        end else begin
            n_acc = m_acc + m_tw;
            n_tw  = sel ? m_dbg : bw;
            n_dbg = ld ? m_sh : m_dbg;
            n_sh  = se ? {m_sh[30:0], sb} : m_sh;
        end
        m_acc = n_acc; m_tw = n_tw; m_sh = n_sh; m_dbg = n_dbg;
        @(negedge clk);
        chk("R2 phase_acc", phase_acc, m_acc);
        chk("R7 phase_idx", {20'd0, phase_idx}, {20'd0, top_bits(m_acc)});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(1'b0, '0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, 1'b0);
        chk("R1 acc after reset", phase_acc, 32'd0);
        chk("R1 idx after reset", {20'd0, phase_idx}, 32'd0);
        rst = 1'b0;
    endtask

    // shift a word MSB first, leaving select as given
    task automatic shift_word(input logic sel, input logic [31:0] w);
        for (int i = 31; i >= 0; i--) step(sel, 32'hDEAD_0000, 1'b1, w[i], 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d0, d1;
        int unsigned wrap_at;
        void'($urandom(32'd20240917));
        @(negedge clk);
        do_reset();

        // R2 wrap with a large bus word
        step(1'b0, 32'hF000_0001, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 32'hF000_0001, 1'b0, 1'b0, 1'b0);
        chk("R2 wrapped value", phase_acc, 32'hF000_0001 * 32'd6);

        // R6 latency and no reset on change
        prev_acc = phase_acc;
        step(1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0);
        d0 = phase_acc - prev_acc; prev_acc = phase_acc;
        step(1'b0, 32'h0000_0100, 1'b0, 1'b0, 1'b0);
        d1 = phase_acc - prev_acc;
        chk("R6 old word on change edge", d0, 32'hF000_0001);
        chk("R6 new word next edge", d1, 32'h0000_0100);

        // R3 shift a word MSB first, R4 held until load, R5 debug select
        shift_word(1'b0, 32'h8000_0003);
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);   // held word still zero
        prev_acc = phase_acc;
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R4 no load keeps zero word", phase_acc - prev_acc, 32'h0);
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b1);   // load
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);   // tw takes it
        prev_acc = phase_acc;
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R3 MSB-first debug word", phase_acc - prev_acc, 32'h8000_0003);

        // R4 shift and load in the same cycle: load takes pre-shift value
        step(1'b1, 32'h0, 1'b1, 1'b0, 1'b1);
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        prev_acc = phase_acc;
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R4 simultaneous shift excluded", phase_acc - prev_acc, 32'h8000_0003);
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b1);
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        prev_acc = phase_acc;
        step(1'b1, 32'h0, 1'b0, 1'b0, 1'b0);
        chk("R4 later load sees shifted bit", phase_acc - prev_acc, 32'h0000_0006);

        // R5 switch back to bus, phase continues (R6)
        prev_acc = phase_acc;
        step(1'b0, 32'h0000_0010, 1'b0, 1'b0, 1'b0);
        chk("R6 switch keeps phase", phase_acc, prev_acc + 32'h0000_0006);
        prev_acc = phase_acc;
        step(1'b0, 32'h0000_0010, 1'b0, 1'b0, 1'b0);
        chk("R5 bus word selected", phase_acc - prev_acc, 32'h0000_0010);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], $urandom, r[1], r[2], (r[7:3] == 5'd0));
        end

        // R8 1 kHz word at 50 MSPS: first wrap clock count
        do_reset();
        wrap_at = 0;
        prev_acc = 32'd0;
        for (int n = 1; n <= 50010; n++) begin
            step(1'b0, 32'h0001_4F8B, 1'b0, 1'b0, 1'b0);
            if (wrap_at == 0 && phase_acc < prev_acc) wrap_at = n;
            prev_acc = phase_acc;
        end
        chk("R8 first wrap clock", wrap_at,
            32'((64'h1_0000_0000 + 64'd85898) / 64'd85899 + 64'd1));

        // R1 reset mid-run clears phase
        do_reset();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule